// File: doc/BRIEF.md
# Write-Only Serial Clock-Control Register Slave

This block is a two-wire serial slave that only accepts writes. It fills a bank of eight-bit clock-control registers from a stream of bytes sent in a fixed order. Other logic reads the bank in parallel, for output enables, frequency selection and operating mode. The serial clock and data lines are sampled with the system clock through two-stage synchronizers. Start and stop conditions and clock edges are detected from the synchronized values. The block drives the data line low, through an open-drain pull output, to acknowledge a byte.

A transfer opens with the device address byte. Two prefix bytes follow; their contents carry no meaning but both are acknowledged. After them, data bytes land in register 0, then 1, then 2, and so on. No subaddress exists, so register N can only be changed by resending every register below it. Anything the block does not recognise gets no acknowledge. The block never drives read data.

Top module: `clkcfg_wslave`

## Requirements
- R1: Only a start condition opens a transfer; a stop condition returns the block to idle, and bytes clocked in while idle get no acknowledge. A start is the data line falling while the clock is high; a stop is the data line rising while the clock is high.
- R2: The first byte after a start is shifted in MSB first and holds a 7-bit address with the read/write flag as its LSB. Only the byte 0xD2 (address 0x69, write) is acknowledged. Any other first byte, including 0xD3, gets no acknowledge and leaves every register unchanged until the next start.
- R3: An acknowledge holds `sda_pull_o` high for the whole ninth clock of an accepted byte. It starts at the clock's falling edge after the eighth bit and ends at the next falling edge. At all other times `sda_pull_o` is low.
- R4: The two bytes that follow an accepted address are both acknowledged whatever their contents, and neither changes any register.
- R5: Data byte k after the two prefix bytes (k counted from 0) is written to register k. Register k appears on `regs_o[8k+7:8k]`.
- R6: At most NUM_REGS (10) data bytes are accepted per transfer. Any later byte gets no acknowledge and is discarded, and the block then ignores the bus until the next start.
- R7: Registers not written in a transfer keep their previous values.
- R8: After reset, register 0 reads 0xF4 and every other register reads 0xFF.
- R9: A start that arrives partway through a byte abandons that byte without writing it, and address reception begins again.
- R10: A transfer ended by a stop before any data byte has been completed leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | When high, the pad pulls the data line low (acknowledge) |
| regs_o | output | NUM_REGS*8 | Register bank, register k on bits 8k+7 to 8k |

## Verification
The bench sends a full ten-byte transfer, which shows that the data order lands each byte in its own register. A short transfer then shows that later registers are retained. A twelve-byte transfer separates the acknowledged bytes from the refused bytes past the limit. Wrong-address and read-flag bytes, and bytes clocked while idle, show that the address gate refuses them. Stops during the prefix and starts in the middle of a byte show that a partial byte is never written. A behavioural model of registers and acknowledge is compared against the outputs on every clock once each line change has settled.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_t;

  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/clkcfg_rstsync.sv
module clkcfg_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/clkcfg_lineio.sv
module clkcfg_lineio #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_last_q, sda_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_last_q <= 1'b1;
      sda_last_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      scl_last_q <= scl_pipe_q[SYNC_STAGES-1];
      sda_last_q <= sda_pipe_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s     = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_last_q;
  assign scl_fall  = ~scl_s & scl_last_q;
  assign start_det = scl_s & scl_last_q & sda_last_q & ~sda_s;
  assign stop_det  = scl_s & scl_last_q & ~sda_last_q & sda_s;
endmodule

// File: rtl/clkcfg_rxfsm.sv
module clkcfg_rxfsm
  import clkcfg_pkg::*;
#(
  parameter int         NUM_REGS     = 10,
  parameter int         PREFIX_BYTES = 2,
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  localparam int        IDX_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int        CNT_W        = $clog2(PREFIX_BYTES + NUM_REGS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             ack_o,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  rx_state_t        state_q, state_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       shr_q, shr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ack_q, ack_d;
  logic [CNT_W-1:0] data_idx;
  logic             byte_done, accept;

  assign data_idx  = cnt_q - CNT_W'(PREFIX_BYTES + 1);
  assign byte_done = (state_q == ST_RECV) && scl_fall && (bit_q == 4'(BYTE_BITS));

  always_comb begin
    if (cnt_q == '0)                           accept = (shr_q == {DEV_ADDR, 1'b0});
    else if (cnt_q <= CNT_W'(PREFIX_BYTES))    accept = 1'b1;
    else                                       accept = (data_idx < CNT_W'(NUM_REGS));
  end

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shr_d   = shr_q;
    cnt_d   = cnt_q;
    ack_d   = ack_q;
    wr_en   = 1'b0;
    if (start_det) begin
      state_d = ST_RECV;
      bit_d   = '0;
      cnt_d   = '0;
      ack_d   = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (scl_rise && (bit_q < 4'(BYTE_BITS))) begin
            shr_d = {shr_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (byte_done) begin
            if (accept) begin
              state_d = ST_ACK;
              ack_d   = 1'b1;
              wr_en   = (cnt_q > CNT_W'(PREFIX_BYTES));
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d = ST_RECV;
            ack_d   = 1'b0;
            bit_d   = '0;
            cnt_d   = cnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shr_q   <= '0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shr_q   <= shr_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
    end
  end

  assign ack_o   = ack_q;
  assign wr_idx  = data_idx[IDX_W-1:0];
  assign wr_data = shr_q;
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
  parameter int         NUM_REGS   = 10,
  parameter logic [7:0] RESET_REG0 = 8'hF4,
  parameter logic [7:0] RESET_FILL = 8'hFF,
  localparam int        IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = (g == 0) ? RESET_REG0 : RESET_FILL;
    logic [7:0] val_q;
    logic       load;

    assign load = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    val_q <= RST_VAL;
      else if (load) val_q <= wr_data;
    end

    assign regs_o[g*8 +: 8] = val_q;
  end
endmodule

// File: rtl/clkcfg_wslave.sv
module clkcfg_wslave #(
  parameter int         NUM_REGS     = 10,
  parameter int         PREFIX_BYTES = 2,
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] RESET_REG0   = 8'hF4,
  parameter logic [7:0] RESET_FILL   = 8'hFF,
  localparam int        IDX_W        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic             rst_n_int;
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  clkcfg_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  clkcfg_lineio #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkcfg_rxfsm #(
    .NUM_REGS     (NUM_REGS),
    .PREFIX_BYTES (PREFIX_BYTES),
    .DEV_ADDR     (DEV_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ack_o     (sda_pull_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  clkcfg_regbank #(
    .NUM_REGS   (NUM_REGS),
    .RESET_REG0 (RESET_REG0),
    .RESET_FILL (RESET_FILL)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/clkcfg_wslave_chk.sv
module clkcfg_wslave_chk #(
  parameter int NUM_REGS = 10,
  parameter int IDX_W    = 4
) (
  input logic                  clk,
  input logic                  rst_n_int,
  input logic                  scl_s,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_pull_o,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] regs_o
);
  // R3: the acknowledge is raised only while the clock line is low
  assert_ack_rise_low_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(sda_pull_o) |-> !scl_s);

  // R3: the acknowledge is released only while the clock line is low
  assert_ack_fall_low_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(sda_pull_o) |-> !scl_s);

  // R5: a register changes only together with a fresh acknowledge
  assert_write_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(regs_o) |-> $rose(sda_pull_o));

  // R6: no write targets an index past the bank
  assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  // R9: a start leaves the data line released
  assert_start_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    start_det |=> !sda_pull_o);

  // R1: a stop leaves the data line released
  assert_stop_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    stop_det |=> !sda_pull_o);
endmodule

bind clkcfg_wslave clkcfg_wslave_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n_int  (rst_n_int),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .sda_pull_o (sda_pull_o),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .regs_o     (regs_o)
);

// File: tb/sim_clkcfg_wslave.sv
module sim_clkcfg_wslave;
  localparam int NR = 10;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] regs;
  wire  sda_line = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  clkcfg_wslave u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .regs_o     (regs)
  );

  int vectors = 0;
  int fails = 0;
  int settle = 0;
  bit cmp_on = 1'b0;

  logic [7:0] exp_r [NR];
  logic exp_ack = 1'b0;
  bit   active = 1'b0;
  bit   dead = 1'b0;
  int   nbytes = 0;

  function automatic logic [NR*8-1:0] exp_flat();
    logic [NR*8-1:0] f;
    for (int k = 0; k < NR; k++) f[k*8 +: 8] = exp_r[k];
    return f;
  endfunction

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      if (settle > 0) settle--;
      else begin
        chk("R5 R7 register bank", 80'(regs), 80'(exp_flat()));
        chk("R3 acknowledge line", 80'(sda_pull), 80'(exp_ack));
      end
    end
  end

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    scl_m = c;
    sda_m = d;
    settle = 6;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    drive(1'b0, b);
    idle(HP);
    drive(1'b1, b);
    idle(HP);
    drive(1'b0, b);
  endtask

  task automatic do_start();
    drive(1'b0, 1'b1);
    idle(HP);
    drive(1'b1, 1'b1);
    idle(HP);
    drive(1'b1, 1'b0);
    active = 1'b1;
    dead = 1'b0;
    nbytes = 0;
    exp_ack = 1'b0;
    idle(HP);
    drive(1'b0, 1'b0);
    idle(4);
  endtask

  task automatic do_stop();
    drive(1'b0, 1'b0);
    idle(HP);
    drive(1'b1, 1'b0);
    idle(HP);
    drive(1'b1, 1'b1);
    active = 1'b0;
    idle(HP);
  endtask

  task automatic send_byte(input logic [7:0] v, input string tag);
    bit acc;
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i]);
      if (i != 0) idle(4);
    end
    acc = 1'b0;
    if (active && !dead) begin
      if (nbytes == 0)      acc = (v == 8'hD2);
      else if (nbytes <= 2) acc = 1'b1;
      else                  acc = ((nbytes - 3) < NR);
      if (acc && nbytes >= 3) exp_r[nbytes-3] = v;
      if (!acc) dead = 1'b1;
    end
    exp_ack = acc;
    idle(4);
    drive(1'b0, 1'b1);
    idle(HP);
    drive(1'b1, 1'b1);
    idle(HP - 1);
    chk(tag, 80'(sda_pull), 80'(acc));
    drive(1'b0, 1'b1);
    exp_ack = 1'b0;
    if (acc) nbytes++;
    idle(4);
  endtask

  task automatic header();
    send_byte(8'hD2, "R2 address 0xD2 acknowledged");
    send_byte(8'h5A, "R4 command prefix acknowledged");
    send_byte(8'h00, "R4 count prefix acknowledged");
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    exp_r[0] = 8'hF4;
    for (int k = 1; k < NR; k++) exp_r[k] = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R8 reset defaults", 80'(regs), 80'(exp_flat()));
    chk("R3 no acknowledge after reset", 80'(sda_pull), 80'(0));
    cmp_on = 1'b1;

    // R5: full ten-byte transfer
    do_start();
    header();
    for (int k = 0; k < NR; k++) send_byte(8'(8'h10 + 8'(k * 17)), "R5 data byte acknowledged");
    do_stop();
    chk("R5 full transfer contents", 80'(regs), 80'(exp_flat()));

    // R2: wrong address and read flag
    do_start();
    send_byte(8'hD4, "R2 wrong address refused");
    send_byte(8'h00, "R2 byte after refusal ignored");
    send_byte(8'h77, "R2 byte after refusal ignored");
    do_stop();
    do_start();
    send_byte(8'hD3, "R2 read flag refused");
    send_byte(8'h11, "R2 byte after read flag ignored");
    do_stop();
    chk("R2 registers untouched", 80'(regs), 80'(exp_flat()));

    // R7: short transfer keeps the rest
    do_start();
    header();
    send_byte(8'hA1, "R7 data byte 0");
    send_byte(8'hB2, "R7 data byte 1");
    send_byte(8'hC3, "R7 data byte 2");
    do_stop();
    chk("R7 short transfer keeps upper registers", 80'(regs), 80'(exp_flat()));

    // R6: beyond the limit
    do_start();
    header();
    for (int k = 0; k < NR; k++) send_byte(8'(8'hE0 ^ 8'(k)), "R6 data byte within limit");
    send_byte(8'h3C, "R6 eleventh byte refused");
    send_byte(8'h4D, "R6 twelfth byte refused");
    do_stop();
    chk("R6 limit contents", 80'(regs), 80'(exp_flat()));

    // R1: bytes while idle
    send_byte(8'hD2, "R1 address while idle refused");
    send_byte(8'h00, "R1 byte while idle refused");
    chk("R1 idle bytes change nothing", 80'(regs), 80'(exp_flat()));

    // R9: repeated start in the middle of a data byte and of an address byte
    do_start();
    header();
    send_byte(8'h66, "R9 data byte before abort");
    for (int i = 0; i < 4; i++) begin send_bit(1'b0); idle(4); end
    do_start();
    for (int i = 0; i < 3; i++) begin send_bit(1'b1); idle(4); end
    do_start();
    header();
    send_byte(8'h99, "R9 data byte after restart");
    do_stop();
    chk("R9 restart writes register 0 only", 80'(regs), 80'(exp_flat()));

    // R10: stop inside the prefix and inside the first data byte
    do_start();
    send_byte(8'hD2, "R10 address acknowledged");
    send_byte(8'hFF, "R10 command acknowledged");
    do_stop();
    do_start();
    header();
    for (int i = 0; i < 5; i++) begin send_bit(1'b0); idle(4); end
    do_stop();
    chk("R10 early stop writes nothing", 80'(regs), 80'(exp_flat()));

    cmp_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule